// File: doc/BRIEF.md
# Paged Codec Register Access Sequencer

This block sits between a host request port and a 16-bit serial frame master. It turns a single host request into the complete sequence of frames a paged codec expects. A write becomes a command frame followed by one data frame. A read of N registers becomes a command frame followed by N receive-only frames. The codec advances its register address by itself for each extra word in a burst.

The sequencer forms the command word, starts each frame only after the master reports the previous one complete, and holds the chip select across all frames of one transaction. Each word read back is handed to the host through a one-cycle valid strobe. A one-cycle done pulse closes the transaction. The serial shifting, clock edges and clock generation belong to the frame master.

Top module: `codec_seq`

## Requirements
- R1: The first frame of every transaction carries the command word: bit 15 is the read flag (1 = read), bits [14:11] the page, bits [10:5] the register address, and bits [4:0] are zero. The receive enable is low for this frame.
- R2: A write issues exactly two frames, the command word and then the write data word, both with the receive enable low.
- R3: A read with count N (1 to 63) issues the command frame and then N frames with a transmit word of zero and the receive enable high. The received word of each such frame appears on `rd_data_o` with `rd_valid_o` high for one cycle, in the cycle after that frame's completion is seen.
- R4: `cs_o` is high when the first frame starts and stays high between frames. It falls in the cycle after the final frame's completion is seen.
- R5: A read with count 0 starts no frame, never raises `cs_o`, and pulses `done_o` in the cycle after acceptance.
- R6: `req_ready_o` is high only while no transaction is open. A request presented while it is low is ignored.
- R7: `done_o` is a one-cycle pulse in the same cycle that `cs_o` falls, which for a read is also the cycle of the last `rd_valid_o`.
- R8: At most one frame is outstanding. `frm_start_o` is a one-cycle pulse and is not raised again until `frm_done_i` has been seen.
- R9: After reset, `cs_o`, `frm_start_o`, `rd_valid_o` and `done_o` are low and `req_ready_o` is high.
- R10: The read count is ignored for writes. A write with a nonzero count still issues exactly two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| req_ready_o | output | 1 | Sequencer idle, request accepted this cycle if req_i |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_page_i | input | 4 | Codec page |
| req_addr_i | input | 6 | Start register address |
| req_wdata_i | input | 16 | Write data |
| req_cnt_i | input | 6 | Number of registers to read |
| rd_valid_o | output | 1 | One-cycle strobe for each returned word |
| rd_data_o | output | 16 | Returned register word |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| frm_start_o | output | 1 | Start one frame on the serial master |
| frm_tx_o | output | 16 | Word to transmit in the frame |
| frm_rx_en_o | output | 1 | Frame receives 16 bits |
| frm_done_i | input | 1 | Serial master reports frame complete |
| frm_rx_i | input | 16 | Word received in the completed frame |
| cs_o | output | 1 | Codec chip select, active high |

## Verification
A wrong phase or a corrupted burst count shows at the frame port at the next frame start. The frame after the command word would carry the write data instead of a zero receive frame, or the reverse. An extra or missing receive frame shows up before the next request. A chip select that drops early or lingers is visible in the cycle after the frame completion that should end the transaction, and so is a done pulse out of step with it. A lost handshake would leave the sequencer out of idle, so the next request is never accepted.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_FIN} seq_st_e;
  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RX} seq_ph_e;
endpackage

// File: rtl/codec_cmd_fmt.sv
module codec_cmd_fmt #(
  parameter int DW = 16,
  parameter int PW = 4,
  parameter int AW = 6
) (
  input  logic          rd_i,
  input  logic [PW-1:0] page_i,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] cmd_o
);
  localparam int PAD = DW - 1 - PW - AW;

  generate
    if (PAD > 0) begin : g_pad
      assign cmd_o = {rd_i, page_i, addr_i, {PAD{1'b0}}};
    end else begin : g_nopad
      assign cmd_o = {rd_i, page_i, addr_i};
    end
  endgenerate
endmodule

// File: rtl/codec_burst_ctr.sv
module codec_burst_ctr #(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          dec_i,
  output logic          last_o
);
  logic [CW-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (load_i) rem_q <= cnt_i;
    else if (dec_i)  rem_q <= rem_q - 1'b1;
  end

  assign last_o = (rem_q == CW'(1));

  // R3: never count below zero
  p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (rem_q != '0));
endmodule

// File: rtl/codec_seq_fsm.sv
module codec_seq_fsm
  import codec_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_rd_i,
  input  logic          cnt_zero_i,
  input  logic [DW-1:0] cmd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          last_i,
  input  logic          frm_done_i,
  input  logic [DW-1:0] frm_rx_i,
  output logic          ready_o,
  output logic          accept_o,
  output logic          rx_done_o,
  output logic          done_o,
  output logic          cs_o,
  output logic          frm_start_o,
  output logic [DW-1:0] frm_tx_o,
  output logic          frm_rx_en_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o
);
  seq_st_e       st_q;
  seq_ph_e       ph_q;
  logic          rd_q, cs_q, start_q, rxen_q, rdv_q;
  logic [DW-1:0] wd_q, tx_q, rdata_q;

  assign ready_o   = (st_q == ST_IDLE);
  assign accept_o  = ready_o && req_i;
  assign rx_done_o = (st_q == ST_WAIT) && frm_done_i && (ph_q == PH_RX);
  assign done_o    = (st_q == ST_FIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ph_q    <= PH_CMD;
      rd_q    <= 1'b0;
      wd_q    <= '0;
      cs_q    <= 1'b0;
      start_q <= 1'b0;
      tx_q    <= '0;
      rxen_q  <= 1'b0;
      rdv_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      start_q <= 1'b0;
      rdv_q   <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          rd_q <= req_rd_i;
          wd_q <= wdata_i;
          if (req_rd_i && cnt_zero_i) begin
            st_q <= ST_FIN;            // empty burst: no select
          end else begin
            st_q    <= ST_WAIT;
            ph_q    <= PH_CMD;
            cs_q    <= 1'b1;
            start_q <= 1'b1;
            tx_q    <= cmd_i;
            rxen_q  <= 1'b0;
          end
        end
        ST_WAIT: if (frm_done_i) begin
          unique case (ph_q)
            PH_CMD: begin
              start_q <= 1'b1;
              if (rd_q) begin
                ph_q   <= PH_RX;
                tx_q   <= '0;
                rxen_q <= 1'b1;
              end else begin
                ph_q <= PH_WR;
                tx_q <= wd_q;
              end
            end
            PH_WR: begin
              cs_q <= 1'b0;
              st_q <= ST_FIN;
            end
            PH_RX: begin
              rdv_q   <= 1'b1;
              rdata_q <= frm_rx_i;
              if (last_i) begin
                cs_q <= 1'b0;
                st_q <= ST_FIN;
              end else begin
                start_q <= 1'b1;
              end
            end
            default: st_q <= ST_IDLE;
          endcase
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_o        = cs_q;
  assign frm_start_o = start_q;
  assign frm_tx_o    = tx_q;
  assign frm_rx_en_o = rxen_q;
  assign rd_valid_o  = rdv_q;
  assign rd_data_o   = rdata_q;

  p_start_cs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_start_o |-> cs_o);
  p_single_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_start_o |=> !frm_start_o);
  p_done_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cs_o);
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> !ready_o);
  p_zero_skip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && req_rd_i && cnt_zero_i) |=> (done_o && !cs_o));
  p_rx_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_start_o && frm_rx_en_o) |-> (frm_tx_o == '0));
endmodule

// File: rtl/codec_seq.sv
module codec_seq #(
  parameter int DW = 16,
  parameter int PW = 4,
  parameter int AW = 6,
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  output logic          req_ready_o,
  input  logic          req_rd_i,
  input  logic [PW-1:0] req_page_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [CW-1:0] req_cnt_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          done_o,
  output logic          frm_start_o,
  output logic [DW-1:0] frm_tx_o,
  output logic          frm_rx_en_o,
  input  logic          frm_done_i,
  input  logic [DW-1:0] frm_rx_i,
  output logic          cs_o
);
  localparam int PAD = DW - 1 - PW - AW;

  logic [DW-1:0] cmd;
  logic          accept, rx_done, last;

  codec_cmd_fmt #(.DW(DW), .PW(PW), .AW(AW)) u_fmt (
    .rd_i   (req_rd_i),
    .page_i (req_page_i),
    .addr_i (req_addr_i),
    .cmd_o  (cmd)
  );

  codec_burst_ctr #(.CW(CW)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .cnt_i  (req_cnt_i),
    .dec_i  (rx_done),
    .last_o (last)
  );

  codec_seq_fsm #(.DW(DW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .req_rd_i    (req_rd_i),
    .cnt_zero_i  (req_cnt_i == '0),
    .cmd_i       (cmd),
    .wdata_i     (req_wdata_i),
    .last_i      (last),
    .frm_done_i  (frm_done_i),
    .frm_rx_i    (frm_rx_i),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .rx_done_o   (rx_done),
    .done_o      (done_o),
    .cs_o        (cs_o),
    .frm_start_o (frm_start_o),
    .frm_tx_o    (frm_tx_o),
    .frm_rx_en_o (frm_rx_en_o),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o)
  );

  // R1: a transaction opens with a transmit-only frame whose low field is clear
  p_cmd_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> (frm_start_o && !frm_rx_en_o && (frm_tx_o[PAD-1:0] == '0)));
endmodule

// File: tb/codec_seq_bench.sv
module codec_seq_bench;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        req_i, req_ready_o, req_rd_i;
  logic [3:0]  req_page_i;
  logic [5:0]  req_addr_i, req_cnt_i;
  logic [15:0] req_wdata_i;
  logic        rd_valid_o, done_o, frm_start_o, frm_rx_en_o, frm_done_i, cs_o;
  logic [15:0] rd_data_o, frm_tx_o, frm_rx_i;

  always #2 clk = ~clk;

  codec_seq u_codec_seq (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_ready_o(req_ready_o),
    .req_rd_i(req_rd_i), .req_page_i(req_page_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .req_cnt_i(req_cnt_i), .rd_valid_o(rd_valid_o),
    .rd_data_o(rd_data_o), .done_o(done_o), .frm_start_o(frm_start_o),
    .frm_tx_o(frm_tx_o), .frm_rx_en_o(frm_rx_en_o), .frm_done_i(frm_done_i),
    .frm_rx_i(frm_rx_i), .cs_o(cs_o)
  );

  typedef struct packed {
    logic [15:0] tx;
    logic        rx;
    logic        is_cmd;
    logic        last;
  } frm_t;

  frm_t        fq[$];
  logic [15:0] rq[$];
  int          checks = 0;
  int          errors = 0;

  function automatic logic [15:0] reg_val(logic [3:0] p, logic [5:0] a);
    return ({p, a, 6'b0} ^ 16'h3C5A) + {10'b0, a};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // serial master and codec model
  initial begin
    logic [3:0]  cur_p;
    logic [5:0]  cur_a;
    logic [15:0] rxv;
    frm_t        e;
    int          nfr;
    frm_done_i = 1'b0;
    frm_rx_i   = 16'h0;
    cur_p = '0; cur_a = '0; nfr = 0;
    forever begin
      while (!frm_start_o) @(negedge clk);
      if (fq.size() == 0) begin
        chk(1'b0, "R8 unexpected frame", {16'h0, frm_tx_o}, 32'h0);
        e = '{tx: 16'h0, rx: 1'b0, is_cmd: 1'b0, last: 1'b1};
      end else begin
        e = fq.pop_front();
        if (e.is_cmd) chk(frm_tx_o == e.tx, "R1 command word", {16'h0, frm_tx_o}, {16'h0, e.tx});
        else          chk(frm_tx_o == e.tx, "R2 R3 data frame word", {16'h0, frm_tx_o}, {16'h0, e.tx});
        chk(frm_rx_en_o == e.rx, "R3 receive enable", {31'h0, frm_rx_en_o}, {31'h0, e.rx});
        chk(cs_o, "R4 select at frame start", {31'h0, cs_o}, 32'h1);
      end
      if (e.is_cmd) begin
        cur_p = frm_tx_o[14:11];
        cur_a = frm_tx_o[10:5];
      end
      rxv = 16'hDEAD;
      if (e.rx) begin
        rxv   = reg_val(cur_p, cur_a);
        cur_a = cur_a + 6'd1;
      end
      for (int i = 0; i < 1 + (nfr % 3); i++) begin
        @(negedge clk);
        chk(cs_o && !frm_start_o, "R8 hold while frame open", {30'h0, cs_o, frm_start_o}, 32'h2);
      end
      nfr++;
      frm_done_i = 1'b1;
      frm_rx_i   = rxv;
      @(negedge clk);
      frm_done_i = 1'b0;
      frm_rx_i   = 16'hBEEF;
      chk(cs_o == !e.last, "R4 select after frame", {31'h0, cs_o}, {31'h0, !e.last});
      chk(done_o == e.last, "R7 done with release", {31'h0, done_o}, {31'h0, e.last});
    end
  end

  // monitor: returned words against scoreboard
  initial begin
    logic [15:0] x;
    forever begin
      @(negedge clk);
      if (rd_valid_o) begin
        if (rq.size() == 0) begin
          chk(1'b0, "R3 unexpected read word", {16'h0, rd_data_o}, 32'h0);
        end else begin
          x = rq.pop_front();
          chk(rd_data_o == x, "R3 read word", {16'h0, rd_data_o}, {16'h0, x});
        end
      end
    end
  end

  task automatic run(bit rd, logic [3:0] p, logic [5:0] a, logic [15:0] wd,
                     logic [5:0] cnt, bit poke);
    int guard;
    frm_t f;
    if (!(rd && cnt == 0)) begin
      f = '{tx: {rd, p, a, 5'b0}, rx: 1'b0, is_cmd: 1'b1, last: 1'b0};
      fq.push_back(f);
      if (!rd) begin
        f = '{tx: wd, rx: 1'b0, is_cmd: 1'b0, last: 1'b1};
        fq.push_back(f);
      end else begin
        for (int i = 0; i < int'(cnt); i++) begin
          f = '{tx: 16'h0, rx: 1'b1, is_cmd: 1'b0, last: (i == int'(cnt) - 1)};
          fq.push_back(f);
          rq.push_back(reg_val(p, a + 6'(i)));
        end
      end
    end
    while (!req_ready_o) @(negedge clk);
    req_rd_i = rd; req_page_i = p; req_addr_i = a; req_wdata_i = wd; req_cnt_i = cnt;
    req_i = 1'b1;
    @(negedge clk);
    if (poke) begin
      // R6: stray request while busy must change nothing
      for (int i = 0; i < 3; i++) begin
        req_rd_i = ~rd; req_page_i = ~p; req_addr_i = ~a; req_cnt_i = 6'd2;
        chk(!req_ready_o, "R6 ready low while busy", {31'h0, req_ready_o}, 32'h0);
        @(negedge clk);
      end
    end
    req_i = 1'b0;
    if (rd && cnt == 0) begin
      chk(done_o && !cs_o && !frm_start_o, "R5 empty read done", {29'h0, done_o, cs_o, frm_start_o}, 32'h4);
      @(negedge clk);
      chk(req_ready_o && !cs_o, "R5 back to idle", {30'h0, req_ready_o, cs_o}, 32'h2);
    end else begin
      guard = 0;
      while (!done_o && guard < 2000) begin
        @(negedge clk);
        guard++;
      end
      chk(done_o, "R7 done seen", {31'h0, done_o}, 32'h1);
      @(negedge clk);
      chk(fq.size() == 0, "R2 R10 frames consumed", fq.size(), 0);
      chk(rq.size() == 0, "R3 words consumed", rq.size(), 0);
      chk(req_ready_o && !done_o, "R6 ready after done", {30'h0, req_ready_o, done_o}, 32'h2);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; req_i = 1'b0; req_rd_i = 1'b0; req_page_i = '0;
    req_addr_i = '0; req_wdata_i = '0; req_cnt_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o && !cs_o && !frm_start_o && !rd_valid_o && !done_o, "R9 reset state",
        {27'h0, req_ready_o, cs_o, frm_start_o, rd_valid_o, done_o}, 32'h10);
    run(1'b0, 4'd2,  6'h11, 16'hA5C3, 6'd0,  1'b0);  // R2 plain write
    run(1'b0, 4'd15, 6'h3F, 16'hFFFF, 6'd7,  1'b0);  // R10 count ignored, R1 max fields
    run(1'b1, 4'd1,  6'h05, 16'h0,    6'd1,  1'b0);  // R3 single read
    run(1'b1, 4'd3,  6'h3E, 16'h0,    6'd5,  1'b0);  // R3 burst across wrap
    run(1'b1, 4'd7,  6'h20, 16'h0,    6'd0,  1'b0);  // R5 empty read
    run(1'b1, 4'd9,  6'h02, 16'h1234, 6'd4,  1'b1);  // R6 stray request
    run(1'b1, 4'd0,  6'h00, 16'h0,    6'd63, 1'b0);  // R3 longest burst
    run(1'b0, 4'd0,  6'h00, 16'h0001, 6'd0,  1'b0);  // R1 zero fields
    repeat (4) @(negedge clk);
    chk(!cs_o && req_ready_o, "R4 idle at end", {30'h0, cs_o, req_ready_o}, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule